// File: doc/BRIEF.md
# Link Bandwidth Reservation Table

This block keeps a small table of bidirectional router links and accounts for bandwidth reserved on each of them. Each entry holds a next-hop IP address, a port IP address, an internal port number, a reservable percentage, the link's total bandwidth, the bandwidth already reserved, and the bandwidth still remaining. Software fills four staging fields one word at a time and then issues a save command, which copies the staged fields into the next free slot. A single clear command empties the whole table.

Other logic sends reserve and release requests against a chosen slot. A reserve request is admitted only while the reserved amount stays within the link's reservable share. That share is the total bandwidth multiplied by the percentage and divided by 100, with the fraction dropped. A release returns bandwidth to the link. Each request is answered one cycle later by a grant pulse or a reject pulse. A lookup port finds the slot that holds a given port IP address in the same cycle, and a read port shows any slot's contents.

Top module: `link_bw_table`

## Requirements
- R1: After a synchronous active-low reset the table is empty: `entry_count` is 0, every slot reads invalid, the lookup misses, and neither `req_grant` nor `req_reject` is high.
- R2: A cycle with `stg_valid` high loads `stg_data` into the staging field picked by `stg_sel`. The codes are 0 for next-hop IP, 1 for total bandwidth, 2 for port IP, and 3 for the port word. In the port word, bits 7:0 are the port number and bits 14:8 are the percentage.
- R3: `cmd_save` copies the staged fields into slot `entry_count`, sets its reserved amount to 0 and its remaining amount to the total, and increments `entry_count`. Slots therefore fill in save order.
- R4: `cmd_save` while `entry_count` equals the table depth (8) changes nothing.
- R5: `cmd_clear` invalidates every slot, sets `entry_count` to 0 and suppresses both response pulses. It takes priority over a save or request in the same cycle.
- R6: The reservable limit is floor(total × min(percentage, 100) / 100). A reserve request (`req_op` = 0) is admitted only when reserved + amount ≤ limit.
- R7: An admitted reserve adds the amount to the reserved field, subtracts it from the remaining field, and raises `req_grant` for one cycle on the following cycle.
- R8: A release (`req_op` = 1) on a valid slot is always granted. It lowers the reserved amount by the requested amount, but not below zero, and raises the remaining amount by the same quantity.
- R9: A request to an invalid slot, or a reserve that would exceed the limit, leaves the table unchanged and raises `req_reject` for one cycle on the following cycle. Grant and reject are never high together.
- R10: `lk_hit` and `lk_idx` report, in the same cycle, the lowest valid slot whose port IP equals `lk_ip`.
- R11: The read port shows the contents of slot `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_valid | input | 1 | Load one staging field |
| stg_sel | input | 2 | Staging field code |
| stg_data | input | 32 | Staging field value |
| cmd_save | input | 1 | Commit the staged link to the next slot |
| cmd_clear | input | 1 | Empty the table |
| req_valid | input | 1 | Bandwidth request strobe |
| req_op | input | 1 | 0 reserve, 1 release |
| req_idx | input | 3 | Target slot |
| req_amt | input | 32 | Requested bandwidth |
| req_grant | output | 1 | Previous request admitted |
| req_reject | output | 1 | Previous request refused |
| lk_ip | input | 32 | Port IP to search for |
| lk_hit | output | 1 | Lookup found a slot |
| lk_idx | output | 3 | Lowest matching slot |
| rd_idx | input | 3 | Slot to display |
| rd_valid | output | 1 | Displayed slot holds a link |
| rd_nexthop | output | 32 | Next-hop IP of the slot |
| rd_portip | output | 32 | Port IP of the slot |
| rd_port | output | 8 | Port number of the slot |
| rd_pct | output | 7 | Reservable percentage of the slot |
| rd_total | output | 32 | Total bandwidth |
| rd_reserved | output | 32 | Reserved bandwidth |
| rd_remaining | output | 32 | Remaining bandwidth |
| entry_count | output | 4 | Number of filled slots |

## Verification
The hardest case to reach is a reserve that lands exactly on the floored limit on a link whose percentage does not divide evenly. A total of 777 at 33 percent gives a limit of 256, so one unit too many must be refused. The stimulus saves such a link, reserves exactly 256, and then asks for one more unit. It also reaches the percentage clamp by saving a link at 120 percent, and it reaches a save on a full table and a clear issued in the same cycle as a save and a request. Each of these cases is set up on purpose.

// File: rtl/lbt_pkg.sv
// Shared widths, codes and entry layout for the link bandwidth table.
// Assumes every bandwidth value is an unsigned integer of BW_W bits.
package lbt_pkg;
    parameter int unsigned IP_W   = 32;
    parameter int unsigned BW_W   = 32;
    parameter int unsigned PORT_W = 8;
    parameter int unsigned PCT_W  = 7;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned PROD_W = BW_W + PCT_W;

    typedef enum logic {
        OP_RESERVE = 1'b0,
        OP_RELEASE = 1'b1
    } bw_op_e;

    typedef enum logic [1:0] {
        SEL_NEXTHOP  = 2'd0,
        SEL_TOTAL    = 2'd1,
        SEL_PORTIP   = 2'd2,
        SEL_PORTWORD = 2'd3
    } stage_sel_e;

    typedef struct packed {
        logic              valid;
        logic [IP_W-1:0]   nexthop;
        logic [IP_W-1:0]   portip;
        logic [PORT_W-1:0] port;
        logic [PCT_W-1:0]  pct;
        logic [BW_W-1:0]   total;
        logic [BW_W-1:0]   reserved;
        logic [BW_W-1:0]   remaining;
    } link_entry_t;

    // Reservable share: total times the clamped percentage, divided by 100.
    function automatic logic [BW_W-1:0] share_limit(logic [BW_W-1:0] total,
                                                    logic [PCT_W-1:0] pct);
        logic [PCT_W-1:0]  p;
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] q;
        p    = (pct > PCT_W'(100)) ? PCT_W'(100) : pct;
        prod = PROD_W'(total) * PROD_W'(p);
        q    = prod / PROD_W'(100);
        return q[BW_W-1:0];
    endfunction
endpackage

// File: rtl/lbt_stage.sv
// Staging registers for one link: each strobe loads one field picked by sel.
// Assumes the port word carries the port number in its low PORT_W bits and
// the percentage just above it.
module lbt_stage
    import lbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_valid,
    input  logic [1:0]        stg_sel,
    input  logic [DATA_W-1:0] stg_data,
    output logic [IP_W-1:0]   s_nexthop,
    output logic [BW_W-1:0]   s_total,
    output logic [IP_W-1:0]   s_portip,
    output logic [PORT_W-1:0] s_port,
    output logic [PCT_W-1:0]  s_pct
);
    stage_sel_e sel;
    assign sel = stage_sel_e'(stg_sel);

    // Load the selected staging field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_nexthop <= '0;
            s_total   <= '0;
            s_portip  <= '0;
            s_port    <= '0;
            s_pct     <= '0;
        end else if (stg_valid) begin
            case (sel)
                SEL_NEXTHOP:  s_nexthop <= stg_data[IP_W-1:0];
                SEL_TOTAL:    s_total   <= stg_data[BW_W-1:0];
                SEL_PORTIP:   s_portip  <= stg_data[IP_W-1:0];
                SEL_PORTWORD: begin
                    s_port <= stg_data[PORT_W-1:0];
                    s_pct  <= stg_data[PORT_W+PCT_W-1:PORT_W];
                end
                default: ;
            endcase
        end
    end

    // R2
    stage_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && stg_sel == 2'd1) |=> s_total == $past(stg_data[BW_W-1:0]));
endmodule

// File: rtl/lbt_admit.sv
// Admission arithmetic for one request against one entry. Purely combinational.
// Assumes reserved never exceeds total, so the remaining field cannot wrap.
module lbt_admit
    import lbt_pkg::*;
(
    input  logic            op,
    input  logic [BW_W-1:0] amt,
    input  logic [BW_W-1:0] total,
    input  logic [PCT_W-1:0] pct,
    input  logic [BW_W-1:0] reserved,
    input  logic [BW_W-1:0] remaining,
    output logic            ok,
    output logic [BW_W-1:0] new_reserved,
    output logic [BW_W-1:0] new_remaining
);
    logic [BW_W-1:0] limit;
    logic [BW_W:0]   sum;
    logic [BW_W-1:0] dec;
    bw_op_e          opc;

    assign opc   = bw_op_e'(op);
    assign limit = share_limit(total, pct);
    assign sum   = {1'b0, reserved} + {1'b0, amt};
    assign dec   = (amt > reserved) ? reserved : amt;

    // Choose admission and the updated amounts for the requested operation.
    always_comb begin
        if (opc == OP_RESERVE) begin
            ok            = (sum <= {1'b0, limit});
            new_reserved  = sum[BW_W-1:0];
            new_remaining = remaining - amt;
        end else begin
            ok            = 1'b1;
            new_reserved  = reserved - dec;
            new_remaining = remaining + dec;
        end
    end
endmodule

// File: rtl/lbt_cam.sv
// Parallel port-IP search over all slots; reports the lowest valid match.
// Assumes duplicates are allowed and resolved by slot order.
module lbt_cam
    import lbt_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    localparam int unsigned IDX_W = $clog2(N_LINKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LINKS-1:0]            valid,
    input  logic [N_LINKS-1:0][IP_W-1:0]  ips,
    input  logic [IP_W-1:0]               key,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [N_LINKS-1:0] match;

    genvar g;
    generate
        for (g = 0; g < N_LINKS; g++) begin : g_cmp
            assign match[g] = valid[g] && (ips[g] == key);
        end
    endgenerate

    // Priority pick: scan downward so the lowest matching slot wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_LINKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R10
    lookup_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid[idx] && ips[idx] == key));
endmodule

// File: rtl/link_bw_table.sv
// Link bandwidth reservation table: staged link save, whole-table clear,
// reserve and release admission against a per-link share, port-IP lookup
// and a combinational read port. Assumes one request per cycle.
module link_bw_table
    import lbt_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    localparam int unsigned IDX_W = $clog2(N_LINKS),
    localparam int unsigned CNT_W = $clog2(N_LINKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_valid,
    input  logic [1:0]        stg_sel,
    input  logic [DATA_W-1:0] stg_data,
    input  logic              cmd_save,
    input  logic              cmd_clear,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [BW_W-1:0]   req_amt,
    output logic              req_grant,
    output logic              req_reject,
    input  logic [IP_W-1:0]   lk_ip,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [IP_W-1:0]   rd_nexthop,
    output logic [IP_W-1:0]   rd_portip,
    output logic [PORT_W-1:0] rd_port,
    output logic [PCT_W-1:0]  rd_pct,
    output logic [BW_W-1:0]   rd_total,
    output logic [BW_W-1:0]   rd_reserved,
    output logic [BW_W-1:0]   rd_remaining,
    output logic [CNT_W-1:0]  entry_count
);
    link_entry_t tbl [N_LINKS];
    logic [CNT_W-1:0] count;

    logic [IP_W-1:0]   s_nexthop, s_portip;
    logic [BW_W-1:0]   s_total;
    logic [PORT_W-1:0] s_port;
    logic [PCT_W-1:0]  s_pct;

    logic              adm_ok;
    logic [BW_W-1:0]   adm_res, adm_rem;
    logic              req_ok;
    logic              room;

    logic [N_LINKS-1:0]           valid_v;
    logic [N_LINKS-1:0][IP_W-1:0] ip_v;

    lbt_stage i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_valid (stg_valid),
        .stg_sel   (stg_sel),
        .stg_data  (stg_data),
        .s_nexthop (s_nexthop),
        .s_total   (s_total),
        .s_portip  (s_portip),
        .s_port    (s_port),
        .s_pct     (s_pct)
    );

    lbt_admit i_admit (
        .op            (req_op),
        .amt           (req_amt),
        .total         (tbl[req_idx].total),
        .pct           (tbl[req_idx].pct),
        .reserved      (tbl[req_idx].reserved),
        .remaining     (tbl[req_idx].remaining),
        .ok            (adm_ok),
        .new_reserved  (adm_res),
        .new_remaining (adm_rem)
    );

    genvar g;
    generate
        for (g = 0; g < N_LINKS; g++) begin : g_flat
            assign valid_v[g] = tbl[g].valid;
            assign ip_v[g]    = tbl[g].portip;
        end
    endgenerate

    lbt_cam #(.N_LINKS(N_LINKS)) i_cam (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid_v),
        .ips   (ip_v),
        .key   (lk_ip),
        .hit   (lk_hit),
        .idx   (lk_idx)
    );

    assign req_ok = tbl[req_idx].valid && adm_ok;
    assign room   = (count < CNT_W'(N_LINKS));

    // Table state: clear first, otherwise apply the request and any save.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_clear) begin
            for (int i = 0; i < N_LINKS; i++) tbl[i] <= '0;
            count      <= '0;
            req_grant  <= 1'b0;
            req_reject <= 1'b0;
        end else begin
            req_grant  <= req_valid && req_ok;
            req_reject <= req_valid && !req_ok;
            if (req_valid && req_ok) begin
                tbl[req_idx].reserved  <= adm_res;
                tbl[req_idx].remaining <= adm_rem;
            end
            if (cmd_save && room) begin
                tbl[count[IDX_W-1:0]] <= '{valid: 1'b1, nexthop: s_nexthop,
                                          portip: s_portip, port: s_port,
                                          pct: s_pct, total: s_total,
                                          reserved: '0, remaining: s_total};
                count <= count + 1'b1;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_valid     = tbl[rd_idx].valid;
        rd_nexthop   = tbl[rd_idx].nexthop;
        rd_portip    = tbl[rd_idx].portip;
        rd_port      = tbl[rd_idx].port;
        rd_pct       = tbl[rd_idx].pct;
        rd_total     = tbl[rd_idx].total;
        rd_reserved  = tbl[rd_idx].reserved;
        rd_remaining = tbl[rd_idx].remaining;
    end

    assign entry_count = count;

    // R9
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && req_reject));
    // R9
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!req_grant && !req_reject));
    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(N_LINKS));
    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_clear) |-> (count == '0 && valid_v == '0));

    generate
        for (g = 0; g < N_LINKS; g++) begin : g_inv
            // R8
            balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tbl[g].valid |-> ({1'b0, tbl[g].reserved} + {1'b0, tbl[g].remaining})
                                 == {1'b0, tbl[g].total});
            // R6
            within_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tbl[g].valid |-> tbl[g].reserved <= share_limit(tbl[g].total, tbl[g].pct));
        end
    endgenerate
endmodule

// File: tb/test_link_bw_table.sv
`timescale 1ns/1ps
module test_link_bw_table;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        stg_valid = 0, cmd_save = 0, cmd_clear = 0, req_valid = 0, req_op = 0;
    logic [1:0]  stg_sel = 0;
    logic [31:0] stg_data = 0, req_amt = 0, lk_ip = 0;
    logic [2:0]  req_idx = 0, rd_idx = 0;
    logic        req_grant, req_reject, lk_hit, rd_valid;
    logic [2:0]  lk_idx;
    logic [31:0] rd_nexthop, rd_portip, rd_total, rd_reserved, rd_remaining;
    logic [7:0]  rd_port;
    logic [6:0]  rd_pct;
    logic [3:0]  entry_count;

    link_bw_table i_link_bw_table (
        .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_sel(stg_sel),
        .stg_data(stg_data), .cmd_save(cmd_save), .cmd_clear(cmd_clear),
        .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx), .req_amt(req_amt),
        .req_grant(req_grant), .req_reject(req_reject), .lk_ip(lk_ip),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_nexthop(rd_nexthop), .rd_portip(rd_portip), .rd_port(rd_port),
        .rd_pct(rd_pct), .rd_total(rd_total), .rd_reserved(rd_reserved),
        .rd_remaining(rd_remaining), .entry_count(entry_count)
    );

    int checks = 0, fails = 0;
    bit     m_v[N];
    longint m_nh[N], m_pip[N], m_port[N], m_pct[N], m_bw[N], m_res[N], m_rem[N];
    int     m_cnt;
    bit     m_g, m_r;
    longint s_nh, s_bw, s_pip, s_port, s_pct;
    longint probe = 0;

    function automatic longint lim(longint t, longint p);
        if (p > 100) p = 100;
        return (t * p) / 100;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model update at a rising edge, from the inputs then present.
    task automatic model_edge();
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_cnt = 0; m_g = 0; m_r = 0;
            s_nh = 0; s_bw = 0; s_pip = 0; s_port = 0; s_pct = 0;
            return;
        end
        if (cmd_clear) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_cnt = 0; m_g = 0; m_r = 0;
        end else begin
            m_g = 0; m_r = 0;
            if (req_valid) begin
                int i = req_idx;
                if (!m_v[i]) m_r = 1;
                else if (req_op == 0) begin
                    if (m_res[i] + longint'(req_amt) <= lim(m_bw[i], m_pct[i])) begin
                        m_res[i] += req_amt; m_rem[i] -= req_amt; m_g = 1;
                    end else m_r = 1;
                end else begin
                    longint d = (longint'(req_amt) > m_res[i]) ? m_res[i] : longint'(req_amt);
                    m_res[i] -= d; m_rem[i] += d; m_g = 1;
                end
            end
            if (cmd_save && m_cnt < N) begin
                m_v[m_cnt] = 1; m_nh[m_cnt] = s_nh; m_pip[m_cnt] = s_pip;
                m_port[m_cnt] = s_port; m_pct[m_cnt] = s_pct; m_bw[m_cnt] = s_bw;
                m_res[m_cnt] = 0; m_rem[m_cnt] = s_bw; m_cnt++;
            end
        end
        if (stg_valid) begin
            case (stg_sel)
                2'd0: s_nh  = stg_data;
                2'd1: s_bw  = stg_data;
                2'd2: s_pip = stg_data;
                default: begin s_port = stg_data[7:0]; s_pct = stg_data[14:8]; end
            endcase
        end
    endtask

    // Compare every visible output with the model.
    task automatic compare_all();
        bit eh; int ei;
        chk("R3 entry_count", entry_count, m_cnt);
        chk("R7 req_grant", req_grant, m_g);
        chk("R9 req_reject", req_reject, m_r);
        for (int i = 0; i < N; i++) begin
            rd_idx = 3'(i); #1;
            chk("R11 rd_valid", rd_valid, m_v[i]);
            if (m_v[i]) begin
                chk("R11 rd_nexthop", rd_nexthop, m_nh[i]);
                chk("R11 rd_portip", rd_portip, m_pip[i]);
                chk("R2 rd_port", rd_port, m_port[i]);
                chk("R2 rd_pct", rd_pct, m_pct[i]);
                chk("R11 rd_total", rd_total, m_bw[i]);
                chk("R7 rd_reserved", rd_reserved, m_res[i]);
                chk("R8 rd_remaining", rd_remaining, m_rem[i]);
            end
        end
        eh = 0; ei = 0;
        for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_pip[i] == probe) begin eh = 1; ei = i; end
        lk_ip = 32'(probe); #0.5;
        chk("R10 lk_hit", lk_hit, eh);
        if (eh) chk("R10 lk_idx", lk_idx, ei);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        stg_valid = 0; cmd_save = 0; cmd_clear = 0; req_valid = 0;
        compare_all();
    endtask

    task automatic put(logic [1:0] sel, logic [31:0] d);
        stg_valid = 1; stg_sel = sel; stg_data = d; tick();
    endtask

    task automatic add_link(logic [31:0] nh, logic [31:0] bw, logic [31:0] pip,
                            logic [7:0] port, logic [6:0] pct);
        put(2'd0, nh); put(2'd1, bw); put(2'd2, pip);
        put(2'd3, {17'd0, pct, port});
        cmd_save = 1; tick();
    endtask

    task automatic req(logic op, logic [2:0] idx, logic [31:0] amt);
        req_valid = 1; req_op = op; req_idx = idx; req_amt = amt; tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: empty after reset
        chk("R1 count after reset", entry_count, 0);
        chk("R1 grant after reset", req_grant, 0);
        rd_idx = 0; #0.5;
        chk("R1 slot0 invalid", rd_valid, 0);

        add_link(32'h0A000001, 32'd1000, 32'hC0A80001, 8'd3, 7'd50);
        add_link(32'h0A000002, 32'd777,  32'hC0A80002, 8'd4, 7'd33);
        add_link(32'h0A000003, 32'd5000, 32'hC0A80003, 8'd9, 7'd120);
        rd_idx = 1; #0.5;
        chk("R3 slot1 total", rd_total, 777);
        chk("R2 slot1 pct", rd_pct, 33);

        req(0, 0, 300);
        chk("R7 grant 300", req_grant, 1);
        rd_idx = 0; #0.5;
        chk("R7 remaining 700", rd_remaining, 700);
        req(0, 0, 201);
        chk("R6 over share rejected", req_reject, 1);
        rd_idx = 0; #0.5;
        chk("R9 reserved unchanged", rd_reserved, 300);
        req(0, 0, 200);
        chk("R6 exact share granted", req_grant, 1);
        req(1, 0, 600);
        rd_idx = 0; #0.5;
        chk("R8 release saturates", rd_reserved, 0);
        chk("R8 remaining full", rd_remaining, 1000);

        req(0, 1, 256);
        chk("R6 floored limit 256", req_grant, 1);
        req(0, 1, 1);
        chk("R6 one past floored limit", req_reject, 1);
        req(0, 2, 5000);
        chk("R6 clamp at 100 percent", req_grant, 1);
        req(0, 5, 1);
        chk("R9 invalid slot reserve", req_reject, 1);
        req(1, 6, 1);
        chk("R9 invalid slot release", req_reject, 1);

        probe = 32'hC0A80003; tick();
        chk("R10 hit slot2", lk_idx, 2);
        add_link(32'h0A000004, 32'd400, 32'hC0A80001, 8'd5, 7'd100);
        probe = 32'hC0A80001; tick();
        chk("R10 duplicate picks lowest", lk_idx, 0);

        for (int k = 0; k < 4; k++)
            add_link(32'h0B000000 + 32'(k), 32'd100 + 32'(k), 32'hAC100000 + 32'(k), 8'(k), 7'd80);
        chk("R3 table full", entry_count, 8);
        add_link(32'h0C000000, 32'd9, 32'hDEAD0001, 8'd1, 7'd10);
        chk("R4 save on full ignored", entry_count, 8);
        probe = 32'hDEAD0001; tick();
        chk("R4 ninth link absent", lk_hit, 0);

        cmd_clear = 1; cmd_save = 1; req_valid = 1; req_op = 0; req_idx = 3; req_amt = 1;
        tick();
        chk("R5 clear empties", entry_count, 0);
        chk("R5 clear suppresses grant", req_grant, 0);
        probe = 32'hC0A80001; tick();
        chk("R5 lookup misses after clear", lk_hit, 0);

        add_link(32'h0D000001, 32'd250, 32'hC0A8FF01, 8'd7, 7'd40);
        rd_idx = 0; #0.5;
        chk("R3 refill slot0 total", rd_total, 250);
        req(0, 0, 101);
        chk("R6 limit 100 exceeded", req_reject, 1);
        req(0, 0, 100);
        chk("R7 grant at 100", req_grant, 1);
        tick();
        finish_run();
    end
endmodule